// File: doc/BRIEF.md
# Ring-Chained Deep FIFO

This block builds one deep first-in/first-out buffer out of `N` equal storage slices joined in a ring. Each slice has its own storage, write pointer, read pointer and occupancy, and each slice may hold a write token and a read token. A write strobe is taken only by the slice that holds the write token. A read strobe is taken only by the slice that holds the read token. When a slice writes its last physical location, it sends a one-cycle pulse on its write hand-over line, and the next slice in the ring takes the write token. When a slice reads its last physical location, the read token moves the same way, on a separate read hand-over line. The pulse from the last slice returns to slice 0.

During reset, a start-slice input picks the slice that holds both tokens once reset is released. Reset clears every pointer. The composite empty and full outputs are active low. Each one is asserted only when every slice asserts its own flag. Read data shows the oldest word of the slice that holds the read token, so words come out in the order they were written across slice boundaries.

A solo input, held static while out of reset, selects a single-slice mode. In this mode the start slice keeps both tokens, its pointers wrap inside it, no hand-over pulse is issued, and the composite flags follow that slice alone.

Top module: `fifo_chain`

## Requirements
- R1: While `rst_n` is low at a clock edge, every pointer and count is cleared, and `first_slice` gets both tokens. After reset, `empty_n`=0, `full_n`=1, `slice_empty_n` is all zeros and `slice_full_n` is all ones.
- R2: Words come out on `rd_data` in exactly the order they were accepted, across slice boundaries and across ring wrap-around.
- R3: In ring mode, an accepted write to location DEPTH-1 of the slice holding the write token raises bit i of `xo_wr` (i is that slice) for that one cycle. The next accepted write goes to location 0 of slice (i+1) mod N.
- R4: In ring mode, an accepted read of location DEPTH-1 of the slice holding the read token raises bit i of `xo_rd` for that one cycle. The read token then moves to slice (i+1) mod N.
- R5: In ring mode, `full_n` is low exactly when N*DEPTH words are held. A write strobe while `full_n` is low is ignored: no word is stored and no pulse is issued.
- R6: `empty_n` is low exactly when no word is held. A read strobe while `empty_n` is low is ignored: no word is consumed and no pulse is issued.
- R7: A read and a write in the same cycle are both accepted when the flags allow. This holds even when a write hand-over and a read hand-over fall in that same cycle.
- R8: With `solo`=1, capacity is DEPTH. `xo_wr` and `xo_rd` stay zero, and the start slice's pointers wrap inside it.
- R9: While `empty_n` is high, `rd_data` presents the oldest held word without a read strobe. A read strobe consumes that word at the clock edge.
- R10: The slice given on `first_slice` during reset receives the first DEPTH words written. Its hand-over pulses come first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| solo | input | 1 | 1 = single-slice mode, held static out of reset |
| first_slice | input | IW | Slice given both tokens at reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WIDTH | Oldest held word (show-ahead) |
| empty_n | output | 1 | Composite empty, active low |
| full_n | output | 1 | Composite full, active low |
| slice_empty_n | output | N | Per-slice empty, active low |
| slice_full_n | output | N | Per-slice full, active low |
| xo_wr | output | N | Per-slice write hand-over pulse |
| xo_rd | output | N | Per-slice read hand-over pulse |

## Verification
The write-token hand-over of one slice and the read-token hand-over of another slice can fall on the same clock edge. This happens whenever exactly DEPTH words are held and a read and a write run together. The bench fills DEPTH words and then issues a read and a write every cycle. Both pointers then reach location DEPTH-1 in neighbouring slices together. The scoreboard predicts the one-hot value of both hand-over lines on every cycle, checks the data order, and confirms that the double hand-over actually occurred.

// File: rtl/fifo_chain.sv
module fifo_chain #(
  parameter int N     = 3,
  parameter int DEPTH = 8,
  parameter int WIDTH = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             solo,
  input  logic [IW-1:0]    first_slice,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty_n,
  output logic             full_n,
  output logic [N-1:0]     slice_empty_n,
  output logic [N-1:0]     slice_full_n,
  output logic [N-1:0]     xo_wr,
  output logic [N-1:0]     xo_rd
);

  logic [N-1:0]     wtok, rtok, wgo, rgo, wlast, rlast;
  logic [WIDTH-1:0] slice_q [N];

  assign wgo   = {N{wr_en}} & wtok & slice_full_n;
  assign rgo   = {N{rd_en}} & rtok & slice_empty_n;
  assign xo_wr = wgo & wlast & {N{~solo}};
  assign xo_rd = rgo & rlast & {N{~solo}};

  assign empty_n = solo ? |(rtok & slice_empty_n) : |slice_empty_n;
  assign full_n  = solo ? |(wtok & slice_full_n)  : |slice_full_n;

  for (genvar i = 0; i < N; i++) begin : g_sl
    localparam int PV = (i + N - 1) % N;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             wtk, rtk;

    assign wlast[i]         = (wp == AW'(DEPTH - 1));
    assign rlast[i]         = (rp == AW'(DEPTH - 1));
    assign slice_empty_n[i] = (cnt != '0);
    assign slice_full_n[i]  = (cnt != CW'(DEPTH));
    assign wtok[i]          = wtk;
    assign rtok[i]          = rtk;
    assign slice_q[i]       = mem[rp];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
        wtk <= (first_slice == IW'(i));
        rtk <= (first_slice == IW'(i));
      end else begin
        if (wgo[i]) wp <= wlast[i] ? '0 : wp + 1'b1;
        if (rgo[i]) rp <= rlast[i] ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(wgo[i]) - CW'(rgo[i]);
        if (xo_wr[PV])     wtk <= 1'b1;
        else if (xo_wr[i]) wtk <= 1'b0;
        if (xo_rd[PV])     rtk <= 1'b1;
        else if (xo_rd[i]) rtk <= 1'b0;
      end
    end

    always_ff @(posedge clk)
      if (wgo[i]) mem[wp] <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++)
      if (rtok[i]) rd_data = rd_data | slice_q[i];
  end

endmodule

// File: rtl/fifo_chain_chk.sv
module fifo_chain_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         solo,
  input logic         empty_n,
  input logic         full_n,
  input logic [N-1:0] xo_wr,
  input logic [N-1:0] xo_rd,
  input logic [N-1:0] wtok,
  input logic [N-1:0] rtok
);

  // R1
  reset_flags_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!empty_n && full_n));

  // R3
  wtok_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(wtok) == 1);

  // R4
  rtok_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(rtok) == 1);

  // R3
  wr_pulse_lone_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(xo_wr));

  // R5
  full_no_wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !full_n |-> xo_wr == '0);

  // R6
  empty_no_rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) !empty_n |-> xo_rd == '0);

  // R8
  solo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) solo |-> (xo_wr == '0 && xo_rd == '0));

  for (genvar i = 0; i < N; i++) begin : g_hand
    // R3
    wr_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xo_wr[i] |=> wtok[(i + 1) % N]);
    // R4
    rd_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xo_rd[i] |=> rtok[(i + 1) % N]);
  end

endmodule

bind fifo_chain fifo_chain_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .solo(solo), .empty_n(empty_n), .full_n(full_n),
  .xo_wr(xo_wr), .xo_rd(xo_rd), .wtok(wtok), .rtok(rtok)
);

// File: tb/fifo_chain_bench.sv
module fifo_chain_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3, DEPTH = 8, WIDTH = 9;
  localparam int IW = 2;

  logic clk = 0, rst_n = 0, solo = 0, wr_en = 0, rd_en = 0;
  logic [IW-1:0] first_slice = '0;
  logic [WIDTH-1:0] wr_data = '0;
  logic [WIDTH-1:0] rd_data;
  logic empty_n, full_n;
  logic [N-1:0] slice_empty_n, slice_full_n, xo_wr, xo_rd;

  int checks = 0, failures = 0, occ = 0, cap = N * DEPTH;
  int wsl = 0, wpos = 0, rsl = 0, rpos = 0, both_seen = 0;
  bit run = 0;
  logic [WIDTH-1:0] exp_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  fifo_chain #(.N(N), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo_chain (.*);

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (run && rst_n) begin
      bit wok, rok;
      logic [N-1:0] exw, exr;
      chk(full_n == (occ != cap), "R5 full_n", full_n, occ != cap);
      chk(empty_n == (occ != 0), "R6 empty_n", empty_n, occ != 0);
      wok = wr_en && occ < cap;
      rok = rd_en && occ > 0;
      exw = (!solo && wok && wpos == DEPTH - 1) ? N'(1) << wsl : '0;
      exr = (!solo && rok && rpos == DEPTH - 1) ? N'(1) << rsl : '0;
      chk(xo_wr == exw, "R3 xo_wr", xo_wr, exw);
      chk(xo_rd == exr, "R4 xo_rd", xo_rd, exr);
      if (exw != 0 && exr != 0) both_seen++;
      if (occ > 0) chk(rd_data == exp_q[0], "R2/R9 rd_data", rd_data, exp_q[0]);
      if (rok) void'(exp_q.pop_front());
      if (wok) begin
        if (wpos == DEPTH - 1) begin wpos = 0; if (!solo) wsl = (wsl + 1) % N; end
        else wpos++;
      end
      if (rok) begin
        if (rpos == DEPTH - 1) begin rpos = 0; if (!solo) rsl = (rsl + 1) % N; end
        else rpos++;
      end
      occ = occ + int'(wok) - int'(rok);
    end
  end

  // driver: pushes the expected word when the write will be taken
  task automatic drive(bit w, bit r);
    @(posedge clk); #1;
    wr_en = w; rd_en = r; wr_data = WIDTH'($urandom);
    if (w && occ < cap) exp_q.push_back(wr_data);
  endtask

  task automatic do_reset(bit s, int first);
    @(posedge clk); #1;
    run = 0; rst_n = 0; wr_en = 0; rd_en = 0; solo = s; first_slice = IW'(first);
    repeat (3) @(posedge clk);
    #1;
    exp_q.delete(); occ = 0; wpos = 0; rpos = 0; wsl = first; rsl = first;
    cap = s ? DEPTH : N * DEPTH;
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(empty_n == 0 && full_n == 1, "R1 flags", {empty_n, full_n}, 2'b01);
    chk(slice_empty_n == '0 && slice_full_n == '1, "R1 slice flags",
        {slice_empty_n, slice_full_n}, {N'(0), {N{1'b1}}});
    run = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 R2 R5 R6 ring mode, start slice 0, over-fill and over-drain
    do_reset(0, 0);
    for (int i = 0; i < N * DEPTH + 3; i++) drive(1, 0);
    for (int i = 0; i < N * DEPTH + 3; i++) drive(0, 1);
    drive(0, 0);
    chk(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);

    // R10 R7: start slice 2, hold DEPTH words, read+write together
    do_reset(0, 2);
    for (int i = 0; i < DEPTH; i++) drive(1, 0);
    for (int i = 0; i < 5 * DEPTH; i++) drive(1, 1);
    drive(0, 0);
    chk(both_seen > 0, "R7 dual hand-over", both_seen, 1);

    // R2 random mix in ring mode
    for (int i = 0; i < 600; i++) drive($urandom_range(0, 2) != 0, $urandom_range(0, 2) != 0);
    for (int i = 0; i < 600; i++) drive($urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0);

    // R8 solo mode on slice 1
    do_reset(1, 1);
    for (int i = 0; i < DEPTH + 2; i++) drive(1, 0);
    for (int i = 0; i < 300; i++) drive($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    for (int i = 0; i < DEPTH + 2; i++) drive(0, 1);
    drive(0, 0);
    @(negedge clk);
    run = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule